// File: doc/BRIEF.md
# Decrement-and-Branch Loop Unit

This unit carries out the counted-loop branch step of a 32-bit processor. Each time it gets a request, it looks at a condition flag, a 32-bit counter register, the program counter and a signed 16-bit displacement. From these it decides whether the loop continues, and it produces the updated counter, a write-enable for the counter and the next program counter. Counting uses only the low 16 bits of the register. The loop ends when that half wraps to all ones. The upper 16 bits always come out unchanged.

The program-counter input is the address of the displacement word. The fall-through address is therefore that input plus 2. The branch target is that input plus the sign-extended displacement, with 32-bit wraparound.

One case is ambiguous: the condition is true and the low half is zero. The parameter `COUNT_FIRST` chooses how it resolves.
- With the default (0), the true condition wins. Nothing is written back.
- With 1, the expiring count wins. The low half becomes all ones and is written back.

In both cases the branch is not taken. All outputs are registered and appear one cycle after the request strobe.

Top module: `dbloop_unit`

## Requirements
- R1: After reset, `out_valid`, `reg_we`, `branch_taken`, `reg_out` and `pc_next` are all zero.
- R2: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high, and low otherwise.
- R3: With `cond_true` low, `reg_out[15:0]` is `reg_in[15:0]` minus 1 modulo 2^16, `reg_out[31:16]` equals `reg_in[31:16]`, and `reg_we` is 1.
- R4: With `cond_true` low and a decremented low half other than 0xFFFF, `branch_taken` is 1 and `pc_next` is `pc_in` plus the sign-extended `disp`, modulo 2^32.
- R5: With `cond_true` low and `reg_in[15:0]` equal to 0, `reg_out[15:0]` is 0xFFFF, `branch_taken` is 0 and `pc_next` is `pc_in`+2.
- R6: With `COUNT_FIRST`=0 and `cond_true` high, `reg_we` is 0, `reg_out` equals `reg_in`, `branch_taken` is 0 and `pc_next` is `pc_in`+2, whatever the counter value.
- R7: With `COUNT_FIRST`=1, `cond_true` high and `reg_in[15:0]` equal to 0, `reg_we` is 1, `reg_out` is {`reg_in[31:16]`, 0xFFFF}, `branch_taken` is 0 and `pc_next` is `pc_in`+2.
- R8: With `COUNT_FIRST`=1, `cond_true` high and a nonzero `reg_in[15:0]`, the result matches R6: no write, register unchanged, no branch, `pc_next` is `pc_in`+2.
- R9: If the counter starts at 0x0FFFFFFF, the condition stays false and each result is fed back, the unit takes 0x10000 steps, with 0xFFFF branches, and leaves 0x0FFFFFFF in the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| cond_true | input | 1 | Loop-exit condition is met |
| reg_in | input | 32 | Counter register value |
| pc_in | input | 32 | Address of the displacement word |
| disp | input | 16 | Signed branch displacement |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| reg_out | output | 32 | Updated counter register value |
| reg_we | output | 1 | Write the counter register back |
| branch_taken | output | 1 | Loop continues at the branch target |
| pc_next | output | 32 | Next program counter |

## Verification
A bad decrement or a wrongly chosen policy shows up on `reg_out` and `reg_we` in the same result cycle as the request that caused it. The zero-counter vectors are where the two policies diverge, and there each policy's own unit exposes a wrong result immediately. An error in the upper half, or a wrong exit test, would otherwise stay hidden. Each such error shows either on a single step, or in the full 0x10000-step feedback run as a wrong step count or a wrong final register. A sign-extension error shows in the same cycle as a wrong `pc_next` for negative displacements.

// File: rtl/dbloop_unit.sv
module dbloop_unit #(
  parameter bit COUNT_FIRST = 1'b0,
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int DW = 16,
  parameter int STEP = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          cond_true,
  input  logic [AW-1:0] reg_in,
  input  logic [AW-1:0] pc_in,
  input  logic [DW-1:0] disp,
  output logic          out_valid,
  output logic [AW-1:0] reg_out,
  output logic          reg_we,
  output logic          branch_taken,
  output logic [AW-1:0] pc_next
);
  localparam logic [AW-1:0] STEP_V = AW'(STEP);

  wire [CW-1:0] low     = reg_in[CW-1:0];
  wire [CW-1:0] low_dec = low - 1'b1;
  wire          expired = (low == '0);
  wire [AW-1:0] target  = pc_in + {{(AW-DW){disp[DW-1]}}, disp};
  wire [AW-1:0] fall    = pc_in + STEP_V;

  logic do_dec, do_br;

  always_comb begin
    if (COUNT_FIRST) do_dec = expired | ~cond_true;
    else             do_dec = ~cond_true;
    do_br = do_dec & ~expired;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      reg_out      <= '0;
      reg_we       <= 1'b0;
      branch_taken <= 1'b0;
      pc_next      <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        reg_out      <= {reg_in[AW-1:CW], do_dec ? low_dec : low};
        reg_we       <= do_dec;
        branch_taken <= do_br;
        pc_next      <= do_br ? target : fall;
      end
    end
  end
endmodule

// File: rtl/dbloop_unit_chk.sv
module dbloop_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        cond_true,
  input logic [31:0] reg_in,
  input logic [31:0] pc_in,
  input logic [15:0] disp,
  input logic        out_valid,
  input logic [31:0] reg_out,
  input logic        reg_we,
  input logic        branch_taken,
  input logic [31:0] pc_next
);
  logic seen;
  always_ff @(posedge clk) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> (out_valid == $past(in_valid)));

  p_high_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && out_valid) |-> (reg_out[31:16] == $past(reg_in[31:16])));

  p_write_changes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && out_valid && reg_we) |-> (reg_out[15:0] == $past(reg_in[15:0]) - 16'd1));

  p_no_write_same_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && out_valid && !reg_we) |-> (reg_out == $past(reg_in)));

  p_cond_no_branch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && out_valid && $past(cond_true)) |-> !branch_taken);

  p_exit_no_branch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && out_valid && reg_we && reg_out[15:0] == 16'hFFFF) |-> !branch_taken);

  p_fall_through_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && out_valid && !branch_taken) |-> (pc_next == $past(pc_in) + 32'd2));
endmodule

bind dbloop_unit dbloop_unit_chk u_chk (.*);

// File: tb/test_dbloop_unit.sv
module test_dbloop_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, cond_true = 1'b0;
  logic [31:0] reg_in = '0, pc_in = '0;
  logic [15:0] disp = '0;
  logic        ov0, we0, br0, ov1, we1, br1;
  logic [31:0] ro0, pn0, ro1, pn1;
  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  dbloop_unit #(.COUNT_FIRST(1'b0)) i_dbloop_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cond_true(cond_true),
    .reg_in(reg_in), .pc_in(pc_in), .disp(disp), .out_valid(ov0),
    .reg_out(ro0), .reg_we(we0), .branch_taken(br0), .pc_next(pn0));

  dbloop_unit #(.COUNT_FIRST(1'b1)) i_dbloop_unit_alt (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cond_true(cond_true),
    .reg_in(reg_in), .pc_in(pc_in), .disp(disp), .out_valid(ov1),
    .reg_out(ro1), .reg_we(we1), .branch_taken(br1), .pc_next(pn1));

  localparam int NV = 14;
  localparam logic [80:0] VEC [NV] = '{
    {1'b0, 32'h0000_0000, 32'h0000_1000, 16'hFFFC},
    {1'b1, 32'h0000_0000, 32'h0000_1000, 16'hFFFC},
    {1'b0, 32'h1234_0001, 32'h0000_2000, 16'h0010},
    {1'b1, 32'h1234_0001, 32'h0000_2000, 16'h0010},
    {1'b0, 32'hABCD_8000, 32'h0000_0004, 16'h8000},
    {1'b1, 32'hABCD_8000, 32'h0000_0004, 16'h8000},
    {1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFF0, 16'h0020},
    {1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFF0, 16'h0020},
    {1'b0, 32'h5555_0000, 32'h8000_0000, 16'h7FFE},
    {1'b1, 32'h5555_0000, 32'h8000_0000, 16'h7FFE},
    {1'b0, 32'h0000_0002, 32'h0000_0010, 16'hFFFE},
    {1'b1, 32'hFFFF_0000, 32'hFFFF_FFFE, 16'h0000},
    {1'b0, 32'h8000_7FFF, 32'h0001_0000, 16'hFF00},
    {1'b1, 32'h0001_FFFF, 32'h0000_0100, 16'hFFF0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic c, input logic [31:0] r, input logic [31:0] p,
                      input logic [15:0] d);
    @(negedge clk);
    cond_true = c; reg_in = r; pc_in = p; disp = d; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_pol(input bit pol, input logic c, input logic [31:0] r,
                            input logic [31:0] p, input logic [15:0] d);
    logic dec, br;
    logic [31:0] er, ep;
    string t;
    dec = pol ? (c == 1'b0 || r[15:0] == 16'h0) : (c == 1'b0);
    br  = dec && (r[15:0] != 16'h0);
    er  = dec ? {r[31:16], r[15:0] - 16'd1} : r;
    ep  = br ? p + {{16{d[15]}}, d} : p + 32'd2;
    if (!c) t = (r[15:0] == 0) ? "R5" : "R3/R4";
    else if (!pol) t = "R6";
    else t = (r[15:0] == 0) ? "R7" : "R8";
    if (!pol) begin
      chk({t, " reg_out"}, ro0, er);
      chk({t, " reg_we"}, {31'b0, we0}, {31'b0, dec});
      chk({t, " branch"}, {31'b0, br0}, {31'b0, br});
      chk({t, " pc_next"}, pn0, ep);
    end else begin
      chk({t, " alt reg_out"}, ro1, er);
      chk({t, " alt reg_we"}, {31'b0, we1}, {31'b0, dec});
      chk({t, " alt branch"}, {31'b0, br1}, {31'b0, br});
      chk({t, " alt pc_next"}, pn1, ep);
    end
  endtask

  initial begin : watchdog
    repeat (195000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] cur;
    int iters, brs;
    repeat (3) @(negedge clk);
    chk("R1 out_valid", {31'b0, ov0}, 32'd0);
    chk("R1 reg_out", ro0, 32'd0);
    chk("R1 pc_next", pn1, 32'd0);
    chk("R1 flags", {29'b0, we0, br0, we1}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 idle out_valid", {31'b0, ov0 | ov1}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][80], VEC[i][79:48], VEC[i][47:16], VEC[i][15:0]);
      chk("R2 out_valid", {30'b0, ov0, ov1}, 32'd3);
      expect_pol(1'b0, VEC[i][80], VEC[i][79:48], VEC[i][47:16], VEC[i][15:0]);
      expect_pol(1'b1, VEC[i][80], VEC[i][79:48], VEC[i][47:16], VEC[i][15:0]);
      @(negedge clk);
      chk("R2 out_valid drop", {30'b0, ov0, ov1}, 32'd0);
    end

    cur = 32'h0FFF_FFFF; iters = 0; brs = 0;
    forever begin
      step(1'b0, cur, 32'h0000_4002, 16'hFFFC);
      iters++;
      cur = ro0;
      if (br0) brs++;
      else break;
      if (iters > 70000) break;
    end
    chk("R9 iterations", iters, 32'h10000);
    chk("R9 branches", brs, 32'hFFFF);
    chk("R9 final reg", cur, 32'h0FFF_FFFF);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule